// File: doc/BRIEF.md
# SPI Master with Programmable Chip-Select Setup and Hold

This block is a single-word SPI master transfer engine in clock mode 0. A pulse on `start` launches one transfer: the chip-select line `sync` goes active, waits a programmable setup time, then `sck` toggles through one word while `mosi` shifts out and `miso` is captured. After a programmable hold time `sync` returns to its inactive level and `done` pulses.

The setup and hold delays come from 3-bit codes. A code can give whole SCK periods or half periods (0.5 and 1.5). All delays are counted in ticks of an internal generator that runs at twice the SCK rate, and each tick lasts `DIV` system clocks. Two sets of codes are provided, one for transmit mode and one for receive mode, and `rx_mode` picks between them when the transfer starts. The chip-select polarity and the bit order are also taken at start.

Top module: `spi_cs_timed_master`

## Requirements
- R1: While reset is asserted, `sck` is low, `busy`, `done` and `rx_word` are zero, and `sync` sits at the inactive level (the inverse of `cs_active_high`).
- R2: Setup codes map to half-period counts h as follows: 000→0, 001→2, 010→4, 101→1, 110→3. The first rising `sck` edge follows the `sync` assertion by (h+1)·DIV clocks.
- R3: Hold codes use the same mapping as setup codes, and 011 gives 6 half periods. `sync` deasserts h·DIV clocks after the last falling `sck` edge.
- R4: An unsupported code gives zero delay. The unsupported codes are 100 and 111 in either field, and 011 in the setup field.
- R5: When `start` is accepted, `rx_mode`=1 selects the receive-mode code pair and `rx_mode`=0 selects the transmit-mode pair. The unselected pair has no effect.
- R6: `sync` equals `cs_active_high` from the cycle after `start` until the transfer ends. Outside a transfer it equals the inverse.
- R7: Exactly WORD_W rising `sck` edges occur per transfer. At the n-th rising edge `mosi` holds bit n of `tx_word`, counted from bit 0 when `lsb_first`=1 and from bit WORD_W-1 when `lsb_first`=0.
- R8: `miso` is sampled at each rising `sck` edge. After `done`, `rx_word` holds the sampled bits placed in the same order that R7 defines for `mosi`.
- R9: `busy` rises in the cycle after `start` is accepted. `done` is high for exactly one clock, in the same cycle that `sync` becomes inactive and `busy` falls.
- R10: A `start` pulse while `busy` is high is ignored. It does not disturb the current word, and no second transfer follows.
- R11: Consecutive rising `sck` edges are 2·DIV clocks apart, and `sck` is low outside a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse to begin a transfer when idle |
| tx_word | input | WORD_W | Word to shift out, captured at start |
| rx_mode | input | 1 | 1 selects the receive-mode delay codes, 0 the transmit-mode codes |
| tx_setup_code | input | 3 | Setup delay code, transmit mode |
| tx_hold_code | input | 3 | Hold delay code, transmit mode |
| rx_setup_code | input | 3 | Setup delay code, receive mode |
| rx_hold_code | input | 3 | Hold delay code, receive mode |
| cs_active_high | input | 1 | 1 makes sync active high, 0 makes it active low |
| lsb_first | input | 1 | 1 shifts LSB first, 0 shifts MSB first |
| miso | input | 1 | Serial data in |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse at the end of the hold time |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| sync | output | 1 | Chip select framing the word |
| rx_word | output | WORD_W | Last received word |

## Verification
A wrong delay count or a bad code decode shows up as a misplaced edge. It moves the first rising `sck` edge away from the `sync` assertion, or moves the `sync` release away from the last falling edge, by a whole multiple of DIV clocks, and this is visible within the same transfer. A fault in the shift state shows as a wrong `mosi` bit at one rising edge, as a rising-edge count other than WORD_W, or as a wrong `rx_word` in the cycle `done` pulses. The sweep covers every setup and hold code in both modes, with both polarities and both bit orders, so any decode fault surfaces within one transfer of about thirty SCK half periods.

// File: rtl/spi_cst_pkg.sv
package spi_cst_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_HOLD  = 2'd3
    } cst_state_e;

    localparam int HALF_W = 3;

endpackage

// File: rtl/spi_cst_delay_dec.sv
module spi_cst_delay_dec #(
    parameter bit IS_HOLD = 1'b0
) (
    input  logic [2:0]                       code_i,
    output logic [spi_cst_pkg::HALF_W-1:0]   half_o
);
    logic [2:0] three_clk;

    generate
        if (IS_HOLD) begin : g_hold
            assign three_clk = 3'd6;
        end else begin : g_setup
            assign three_clk = 3'd0;
        end
    endgenerate

    always_comb begin
        case (code_i)
            3'b000:  half_o = 3'd0;
            3'b001:  half_o = 3'd2;
            3'b010:  half_o = 3'd4;
            3'b011:  half_o = three_clk;
            3'b101:  half_o = 3'd1;
            3'b110:  half_o = 3'd3;
            default: half_o = 3'd0;
        endcase
    end

endmodule

// File: rtl/spi_cst_tick_gen.sv
module spi_cst_tick_gen #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run || cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    assign tick = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    generate
        if (DIV > 1) begin : g_gap_chk
            // R11: half-period ticks never come back to back
            a_r11_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate

endmodule

// File: rtl/spi_cst_engine.sv
module spi_cst_engine
    import spi_cst_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [HALF_W-1:0] setup_half,
    input  logic [HALF_W-1:0] hold_half,
    input  logic              cs_active_high,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    output logic              sync,
    output logic [WORD_W-1:0] rx_word
);
    localparam int PW_RAW = $clog2(2 * WORD_W + 1);
    localparam int PW     = (PW_RAW < HALF_W) ? HALF_W : PW_RAW;
    localparam logic [PW-1:0] LAST_EDGE = PW'(2 * WORD_W - 1);

    typedef struct packed {
        cst_state_e        st;
        logic [PW-1:0]     ph;
        logic              sck;
        logic              done;
        logic              pol;
        logic              lsb;
        logic [HALF_W-1:0] setup;
        logic [HALF_W-1:0] hold;
        logic [WORD_W-1:0] tx;
        logic [WORD_W-1:0] rx;
        logic [WORD_W-1:0] rx_out;
    } eng_t;

    eng_t d, q;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                d.ph = '0;
                if (start) begin
                    d.pol   = cs_active_high;
                    d.lsb   = lsb_first;
                    d.tx    = tx_word;
                    d.rx    = '0;
                    d.setup = setup_half;
                    d.hold  = hold_half;
                    d.st    = (setup_half == '0) ? ST_SHIFT : ST_SETUP;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    if (q.ph == PW'(q.setup) - PW'(1)) begin
                        d.ph = '0;
                        d.st = ST_SHIFT;
                    end else begin
                        d.ph = q.ph + PW'(1);
                    end
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    d.ph = q.ph + PW'(1);
                    if (!q.sck) begin
                        d.sck = 1'b1;
                        d.rx  = q.lsb ? WORD_W'({miso, q.rx} >> 1)
                                      : WORD_W'({q.rx, miso});
                    end else begin
                        d.sck = 1'b0;
                        if (q.ph == LAST_EDGE) begin
                            d.ph = '0;
                            if (q.hold == '0) begin
                                d.st     = ST_IDLE;
                                d.done   = 1'b1;
                                d.rx_out = q.rx;
                            end else begin
                                d.st = ST_HOLD;
                            end
                        end else begin
                            d.tx = q.lsb ? (q.tx >> 1) : (q.tx << 1);
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    if (q.ph == PW'(q.hold) - PW'(1)) begin
                        d.ph     = '0;
                        d.st     = ST_IDLE;
                        d.done   = 1'b1;
                        d.rx_out = q.rx;
                    end else begin
                        d.ph = q.ph + PW'(1);
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ph: '0, sck: 1'b0, done: 1'b0, pol: 1'b0,
                   lsb: 1'b0, setup: '0, hold: '0, tx: '0, rx: '0, rx_out: '0};
        end else begin
            q <= d;
        end
    end

    assign busy    = (q.st != ST_IDLE);
    assign done    = q.done;
    assign sck     = q.sck;
    assign mosi    = q.lsb ? q.tx[0] : q.tx[WORD_W-1];
    assign sync    = (q.st == ST_IDLE) ? ~cs_active_high : q.pol;
    assign rx_word = q.rx_out;

    // R11: clock stays low outside a transfer
    a_r11_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.sck);

    // R11: clock moves only on a half-period tick
    a_r11_sck_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(q.sck));

    // R9: done lasts one cycle
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: done coincides with busy falling
    a_r9_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    // R2: setup wait never exceeds the decoded count
    a_r2_setup_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SETUP) |-> (q.ph < PW'(q.setup)));

    // R3: hold wait never exceeds the decoded count
    a_r3_hold_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_HOLD) |-> (q.ph < PW'(q.hold)));

    // R10: a start during the shift phase does not restart the word
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (start && q.st == ST_SHIFT) |=> (q.st != ST_SETUP));

endmodule

// File: rtl/spi_cs_timed_master.sv
module spi_cs_timed_master #(
    parameter int WORD_W = 8,
    parameter int DIV    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              rx_mode,
    input  logic [2:0]        tx_setup_code,
    input  logic [2:0]        tx_hold_code,
    input  logic [2:0]        rx_setup_code,
    input  logic [2:0]        rx_hold_code,
    input  logic              cs_active_high,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic              sck,
    output logic              mosi,
    output logic              sync,
    output logic [WORD_W-1:0] rx_word
);
    import spi_cst_pkg::*;

    logic [2:0]        setup_code, hold_code;
    logic [HALF_W-1:0] setup_half, hold_half;
    logic              tick;

    assign setup_code = rx_mode ? rx_setup_code : tx_setup_code;
    assign hold_code  = rx_mode ? rx_hold_code  : tx_hold_code;

    spi_cst_delay_dec #(.IS_HOLD(1'b0)) setup_dec_i (
        .code_i (setup_code),
        .half_o (setup_half)
    );

    spi_cst_delay_dec #(.IS_HOLD(1'b1)) hold_dec_i (
        .code_i (hold_code),
        .half_o (hold_half)
    );

    spi_cst_tick_gen #(.DIV(DIV)) tick_i (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .tick  (tick)
    );

    spi_cst_engine #(.WORD_W(WORD_W)) eng_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .tick           (tick),
        .start          (start),
        .tx_word        (tx_word),
        .setup_half     (setup_half),
        .hold_half      (hold_half),
        .cs_active_high (cs_active_high),
        .lsb_first      (lsb_first),
        .miso           (miso),
        .busy           (busy),
        .done           (done),
        .sck            (sck),
        .mosi           (mosi),
        .sync           (sync),
        .rx_word        (rx_word)
    );

    // R4: the decoded setup count never comes from the hold-only code
    a_r4_setup_011_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_code == 3'b011) |-> (setup_half == '0));

endmodule

// File: tb/spi_cs_timed_master_tb_top.sv
module spi_cs_timed_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W   = 8;
    localparam int DIV = 2;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         rx_mode = 1'b0;
    logic [2:0]   tx_setup_code = '0, tx_hold_code = '0;
    logic [2:0]   rx_setup_code = '0, rx_hold_code = '0;
    logic         cs_active_high = 1'b1;
    logic         lsb_first = 1'b0;
    logic         miso = 1'b0;
    logic         busy, done, sck, mosi, sync;
    logic [W-1:0] rx_word;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_cs_timed_master #(.WORD_W(W), .DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .rx_mode(rx_mode), .tx_setup_code(tx_setup_code), .tx_hold_code(tx_hold_code),
        .rx_setup_code(rx_setup_code), .rx_hold_code(rx_hold_code),
        .cs_active_high(cs_active_high), .lsb_first(lsb_first), .miso(miso),
        .busy(busy), .done(done), .sck(sck), .mosi(mosi), .sync(sync), .rx_word(rx_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_half(input logic [2:0] c, input bit hold);
        case (c)
            3'b000: return 0;
            3'b001: return 2;
            3'b010: return 4;
            3'b011: return hold ? 6 : 0;
            3'b101: return 1;
            3'b110: return 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit unsup(input logic [2:0] c, input bit hold);
        return (c == 3'b100) || (c == 3'b111) || (c == 3'b011 && !hold);
    endfunction

    function automatic logic bit_at(input logic [W-1:0] v, input bit lsb, input int n);
        return lsb ? v[n] : v[W-1-n];
    endfunction

    task automatic run_xfer(input bit mode, input logic [2:0] sc, input logic [2:0] hc,
                            input logic [2:0] osc, input logic [2:0] ohc,
                            input bit pol, input bit lsb,
                            input logic [W-1:0] word, input logic [W-1:0] slave,
                            input bit inject);
        int cyc, nr, t_rise0, last_rise, t_fall, t_off, eh, es;
        bit prev_sck, seen_done, period_ok, mosi_ok, idle_ok;
        string rs, rh;
        rx_mode = mode;
        if (mode) begin
            rx_setup_code = sc; rx_hold_code = hc; tx_setup_code = osc; tx_hold_code = ohc;
        end else begin
            tx_setup_code = sc; tx_hold_code = hc; rx_setup_code = osc; rx_hold_code = ohc;
        end
        cs_active_high = pol;
        lsb_first = lsb;
        tx_word = word;
        miso = bit_at(slave, lsb, 0);
        @(negedge clk);
        chk(sync == ~pol, "R6", "idle sync level", int'(sync), int'(~pol));
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", int'(busy), 1);
        chk(sync == pol, "R6", "active sync level", int'(sync), int'(pol));
        cyc = 0; nr = 0; t_rise0 = -1; last_rise = -1; t_fall = -1; t_off = -1;
        prev_sck = 1'b0; seen_done = 1'b0; period_ok = 1'b1; mosi_ok = 1'b1;
        while (!seen_done && cyc < 400) begin
            if (inject) start = (cyc == 5 || cyc == 20);
            if (sck && !prev_sck) begin
                if (nr == 0) t_rise0 = cyc;
                else if (cyc - last_rise != 2 * DIV) period_ok = 1'b0;
                last_rise = cyc;
                if (nr < W && mosi != bit_at(word, lsb, nr)) mosi_ok = 1'b0;
                nr++;
                if (nr < W) miso = bit_at(slave, lsb, nr);
            end
            if (!sck && prev_sck) t_fall = cyc;
            if (t_off < 0 && sync != pol) t_off = cyc;
            if (done) seen_done = 1'b1;
            prev_sck = sck;
            if (!seen_done) begin
                @(negedge clk);
                cyc++;
            end
        end
        start = 1'b0;
        es = exp_half(sc, 1'b0);
        eh = exp_half(hc, 1'b1);
        rs = unsup(sc, 1'b0) ? "R4" : (mode ? "R5" : "R2");
        rh = unsup(hc, 1'b1) ? "R4" : (mode ? "R5" : "R3");
        chk(seen_done, "R9", "done seen", int'(seen_done), 1);
        chk(t_rise0 == (es + 1) * DIV, rs, "setup clocks", t_rise0, (es + 1) * DIV);
        chk(t_off - t_fall == eh * DIV, rh, "hold clocks", t_off - t_fall, eh * DIV);
        chk(t_off == cyc, "R9", "done with sync release", cyc, t_off);
        chk(!busy, "R9", "busy low at done", int'(busy), 0);
        chk(nr == W, "R7", "rising edges", nr, W);
        chk(mosi_ok, "R7", "mosi bits", int'(mosi_ok), 1);
        chk(period_ok, "R11", "sck period", int'(period_ok), 1);
        chk(rx_word == slave, "R8", "rx_word", int'(rx_word), int'(slave));
        if (inject) begin
            idle_ok = 1'b1;
            repeat (12) begin
                @(negedge clk);
                if (busy || sck || sync == pol) idle_ok = 1'b0;
            end
            chk(idle_ok, "R10", "no transfer after ignored start", int'(idle_ok), 1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(!sck, "R1", "sck in reset", int'(sck), 0);
        chk(!busy && !done, "R1", "busy/done in reset", int'(busy | done), 0);
        chk(rx_word == '0, "R1", "rx_word in reset", int'(rx_word), 0);
        chk(sync == 1'b0, "R1", "sync inactive in reset", int'(sync), 0);
        cs_active_high = 1'b0;
        @(negedge clk);
        chk(sync == 1'b1, "R1", "sync inactive low-active", int'(sync), 1);
        rst_n = 1'b1;
        @(negedge clk);

        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 8; s++) begin
                for (int h = 0; h < 8; h++) begin
                    logic [W-1:0] w;
                    logic [W-1:0] sl;
                    w  = 8'hA5 ^ 8'(s * 16 + h) ^ (m[0] ? 8'h3C : 8'h00);
                    sl = {w[3:0], w[7:4]} ^ 8'h96;
                    run_xfer(m[0], 3'(s), 3'(h), 3'(s + 3), 3'(h + 5),
                             h[0], s[1], w, sl, 1'b0);
                end
            end
        end

        // R10: start pulses during setup and shift are ignored
        run_xfer(1'b0, 3'b110, 3'b011, 3'b000, 3'b000, 1'b1, 1'b0, 8'hC3, 8'h5A, 1'b1);
        run_xfer(1'b1, 3'b000, 3'b000, 3'b010, 3'b010, 1'b0, 1'b1, 8'h81, 8'h7E, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule